// File: doc/BRIEF.md
# Serial Baud Rate Generator

This block times an asynchronous serial controller. It counts a bus-clock enable that is high one core clock in four. From those counts it makes three pulses: an oversampling tick sixteen times per bit, a bit tick, and an end-of-character pulse that marks one whole character time. A byte-wide rate register, written from the host side, sets the divisor. A two-bit prescaler code picks a factor of 1, 3, 4 or 13. A three-bit rate-select field then multiplies that by a power of two from 1 to 128.

The bit period is the prescaler factor times 16 times 2^R bus clocks. A character lasts 10 bit periods, or 11 when the long-character input is set. The block drives the frame length on a port so that a neighbour can use it. Every counter restarts on a register write, so the new rate takes effect from a clean phase.

A reset normally clears the rate register, which gives the fastest rate. When the boot-select input is high during reset, the register is loaded with 0x33 instead. That value gives prescale 13 and rate divide 8, which is about 1200 baud from a 2 MHz bus clock.

Top module: `baud_gen`

## Requirements
- R1: Bits [5:4] of the rate register select the prescaler factor: code 0 gives 1, code 1 gives 3, code 2 gives 4 and code 3 gives 13.
- R2: Bits [2:0] of the rate register hold a rate select R. With prescaler factor P, os_tick fires on every (P * 2^R)-th counted bus cycle. Register bits 7, 6 and 3 have no effect.
- R3: bit_tick fires on every 16th os_tick and only in a cycle where os_tick is also high.
- R4: frame_len reads 10 when long_char is 0 and 11 when long_char is 1.
- R5: char_end fires on every frame_len-th bit_tick and only together with bit_tick.
- R6: A write (rate_wr high) loads rate_wdata and clears every counter. No tick fires in the write cycle, and the first os_tick comes exactly P * 2^R counted bus cycles later.
- R7: A reset with boot_sel low loads 0x00 into the rate register, so os_tick fires on every counted bus cycle and bit_tick on every 16th.
- R8: A reset with boot_sel high loads 0x33 into the rate register: os_tick every 104 counted bus cycles and bit_tick every 1664.
- R9: Counting happens only in cycles where bus_ce is high. No tick fires in a cycle where bus_ce is low.
- R10: No tick fires while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_sel | input | 1 | Selects the slow boot default for the rate register at reset |
| bus_ce | input | 1 | Bus-clock enable, one core clock in four |
| rate_wr | input | 1 | Write strobe for the rate register |
| rate_wdata | input | 8 | Write data: [5:4] prescaler code, [2:0] rate select |
| long_char | input | 1 | Character-length control: 0 gives a 10-bit frame, 1 gives an 11-bit frame |
| os_tick | output | 1 | 16x oversampling tick |
| bit_tick | output | 1 | One pulse per bit period |
| char_end | output | 1 | One pulse per character time |
| frame_len | output | 4 | Frame length in bits, 10 or 11 |

## Verification
The tick stream is tried in several ways:
- Each prescaler code is run with a rate select of zero. This separates the four prescaler factors from the power-of-two stage.
- Random register values with random filler in the unused bits are run with both frame lengths. These separate the rate-select shift and the frame-length choice, and show that the unused bits are ignored.
- A write is made in the middle of a count, with bus_ce sometimes high in the write cycle. This shows whether the counters restart or keep their old phase.
- Both reset flavours are run. This separates the two reset values of the register.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

   localparam int unsigned REG_W      = 8;
   localparam int unsigned PRE_CODE_W = 2;
   localparam int unsigned PRE_LSB    = 4;
   localparam int unsigned RSEL_W     = 3;
   localparam int unsigned RSEL_LSB   = 0;

   typedef logic [PRE_CODE_W-1:0] pre_code_t;
   typedef logic [RSEL_W-1:0]     rate_sel_t;

   // Prescaler factor for a code; anything outside the listed codes acts as 13.
   function automatic int unsigned pre_factor(input pre_code_t code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 3;
         2'd2:    return 4;
         default: return 13;
      endcase
   endfunction

endpackage

// File: rtl/bgen_rate_reg.sv
module bgen_rate_reg
   import baud_gen_pkg::*;
#(
   parameter logic [REG_W-1:0] BOOT_VALUE = 8'h33,
   parameter int unsigned      PRE_CNT_W  = 4,
   parameter int unsigned      RATE_CNT_W = 7
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  boot_sel,
   input  logic                  wr,
   input  logic [REG_W-1:0]      wdata,
   output logic [PRE_CNT_W-1:0]  pre_last,
   output logic [RATE_CNT_W-1:0] rate_last,
   output logic                  restart
);

   logic [REG_W-1:0] rate_q;
   pre_code_t        code;
   rate_sel_t        rsel;

   always_ff @(posedge clk) begin
      if (!rst_n)
         rate_q <= boot_sel ? BOOT_VALUE : '0;
      else if (wr)
         rate_q <= wdata;
   end

   assign code = rate_q[PRE_LSB +: PRE_CODE_W];
   assign rsel = rate_q[RSEL_LSB +: RSEL_W];

   always_comb begin
      pre_last  = PRE_CNT_W'(pre_factor(code) - 1);
      rate_last = RATE_CNT_W'((32'd1 << rsel) - 32'd1);
   end

   assign restart = wr | ~rst_n;

   // R6: a write lands in the register on the next edge
   a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> rate_q == $past(wdata));

endmodule

// File: rtl/bgen_mod_stage.sv
module bgen_mod_stage #(
   parameter int unsigned CNT_W = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [CNT_W-1:0] last_val,
   output logic             wrap
);

   logic [CNT_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = cnt_q >= last_val;
   assign wrap   = adv & ~clr & at_end;

   always_ff @(posedge clk) begin
      if (clr)
         cnt_q <= '0;
      else if (adv)
         cnt_q <= at_end ? '0 : cnt_q + 1'b1;
   end

   // R6: a clear leaves the stage at count zero
   a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt_q == '0);

   // R9: without an advance the count holds
   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/baud_gen.sv
module baud_gen
   import baud_gen_pkg::*;
#(
   parameter int unsigned      OS_FACTOR   = 16,
   parameter int unsigned      SHORT_FRAME = 10,
   parameter int unsigned      LONG_FRAME  = 11,
   parameter int unsigned      FRAME_W     = 4,
   parameter logic [REG_W-1:0] BOOT_VALUE  = 8'h33
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               boot_sel,
   input  logic               bus_ce,
   input  logic               rate_wr,
   input  logic [REG_W-1:0]   rate_wdata,
   input  logic               long_char,
   output logic               os_tick,
   output logic               bit_tick,
   output logic               char_end,
   output logic [FRAME_W-1:0] frame_len
);

   localparam int unsigned PRE_CNT_W  = 4;
   localparam int unsigned RATE_CNT_W = (1 << RSEL_W) - 1;
   localparam int unsigned OS_CNT_W   = $clog2(OS_FACTOR);

   if (OS_FACTOR < 2 || (OS_FACTOR & (OS_FACTOR - 1)) != 0) begin : g_bad_os
      $error("OS_FACTOR must be a power of two of at least 2");
   end
   if (LONG_FRAME >= (1 << FRAME_W) || SHORT_FRAME < 2) begin : g_bad_frame
      $error("frame lengths do not fit FRAME_W");
   end

   logic [PRE_CNT_W-1:0]  pre_last;
   logic [RATE_CNT_W-1:0] rate_last;
   logic                  restart;
   logic                  pre_wrap;
   logic [FRAME_W-1:0]    frame_last;

   bgen_rate_reg #(
      .BOOT_VALUE (BOOT_VALUE),
      .PRE_CNT_W  (PRE_CNT_W),
      .RATE_CNT_W (RATE_CNT_W)
   ) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .boot_sel  (boot_sel),
      .wr        (rate_wr),
      .wdata     (rate_wdata),
      .pre_last  (pre_last),
      .rate_last (rate_last),
      .restart   (restart)
   );

   bgen_mod_stage #(.CNT_W(PRE_CNT_W)) u_pre (
      .clk (clk), .rst_n (rst_n), .clr (restart), .adv (bus_ce),
      .last_val (pre_last), .wrap (pre_wrap)
   );

   bgen_mod_stage #(.CNT_W(RATE_CNT_W)) u_rate (
      .clk (clk), .rst_n (rst_n), .clr (restart), .adv (pre_wrap),
      .last_val (rate_last), .wrap (os_tick)
   );

   bgen_mod_stage #(.CNT_W(OS_CNT_W)) u_os (
      .clk (clk), .rst_n (rst_n), .clr (restart), .adv (os_tick),
      .last_val (OS_CNT_W'(OS_FACTOR - 1)), .wrap (bit_tick)
   );

   assign frame_len  = long_char ? FRAME_W'(LONG_FRAME) : FRAME_W'(SHORT_FRAME);
   assign frame_last = frame_len - 1'b1;

   bgen_mod_stage #(.CNT_W(FRAME_W)) u_frame (
      .clk (clk), .rst_n (rst_n), .clr (restart), .adv (bit_tick),
      .last_val (frame_last), .wrap (char_end)
   );

   // R3: a bit tick only ever coincides with an oversample tick
   a_r3_bit_in_os: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> os_tick);

   // R5: end of character only with a bit tick
   a_r5_char_in_bit: assert property (@(posedge clk) disable iff (!rst_n)
      char_end |-> bit_tick);

   // R9: ticks need a bus-clock enable
   a_r9_tick_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
      os_tick |-> bus_ce);

   // R6: write cycle is quiet
   a_r6_quiet_write: assert property (@(posedge clk) disable iff (!rst_n)
      rate_wr |-> !os_tick);

   // R10: silent while reset is held
   always_comb begin
      if (!rst_n) a_r10_reset_quiet: assert (!os_tick && !bit_tick && !char_end);
   end

endmodule

// File: tb/tb_baud_gen.sv
module tb_baud_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       boot_sel = 1'b0;
   logic       bus_ce = 1'b0;
   logic       rate_wr = 1'b0;
   logic [7:0] rate_wdata = 8'h00;
   logic       long_char = 1'b0;
   logic       os_tick, bit_tick, char_end;
   logic [3:0] frame_len;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   int    k = 0;
   int    n = 1;
   int    phase = 0;
   string seg_tag = "R7";

   always #5 clk = ~clk;

   baud_gen dut (
      .clk (clk), .rst_n (rst_n), .boot_sel (boot_sel), .bus_ce (bus_ce),
      .rate_wr (rate_wr), .rate_wdata (rate_wdata), .long_char (long_char),
      .os_tick (os_tick), .bit_tick (bit_tick), .char_end (char_end),
      .frame_len (frame_len)
   );

   function automatic int pre_of(input logic [1:0] c);
      case (c)
         2'd0: return 1;
         2'd1: return 3;
         2'd2: return 4;
         default: return 13;
      endcase
   endfunction

   function automatic int period_of(input logic [7:0] d);
      return pre_of(d[5:4]) << d[2:0];
   endfunction

   task automatic chk(input string tag, input int act, input int exp_v, input string what);
      checks++;
      if (act != exp_v) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at k=%0d", tag, what, act, exp_v, k);
      end
   endtask

   // One core clock: drive at negedge, sample 2 ns later, advance the model.
   task automatic step(input logic wr, input logic [7:0] d);
      logic e_os, e_bit, e_ch;
      int   len;
      string t_os, t_bit, t_ch;
      @(negedge clk);
      bus_ce     = (phase == 3);
      phase      = (phase + 1) % 4;
      rate_wr    = wr;
      rate_wdata = d;
      #2;
      e_os = 1'b0; e_bit = 1'b0; e_ch = 1'b0;
      len  = long_char ? 11 : 10;
      if (!rst_n) begin
         t_os = "R10"; t_bit = "R10"; t_ch = "R10";
      end else if (wr) begin
         t_os = "R6"; t_bit = "R6"; t_ch = "R6";
      end else if (!bus_ce) begin
         t_os = "R9"; t_bit = "R9"; t_ch = "R9";
      end else begin
         k++;
         e_os  = (k % n) == 0;
         e_bit = (k % (16 * n)) == 0;
         e_ch  = (k % (16 * n * len)) == 0;
         t_os = seg_tag; t_bit = "R3"; t_ch = "R5";
      end
      chk(t_os,  int'(os_tick),  int'(e_os),  "os_tick");
      chk(t_bit, int'(bit_tick), int'(e_bit), "bit_tick");
      chk(t_ch,  int'(char_end), int'(e_ch),  "char_end");
      chk("R4", int'(frame_len), len, "frame_len");
      if (!rst_n) begin
         k = 0; n = boot_sel ? period_of(8'h33) : 1;
      end else if (wr) begin
         k = 0; n = period_of(d);
      end
   endtask

   task automatic run_bus(input int nbus);
      int seen = 0;
      while (seen < nbus) begin
         step(1'b0, 8'h00);
         if (bus_ce) seen++;
      end
   endtask

   task automatic do_write(input logic [7:0] d, input logic lc);
      @(negedge clk);
      long_char = lc;
      step(1'b1, d);
   endtask

   task automatic do_reset(input logic boot);
      @(negedge clk);
      boot_sel = boot;
      rst_n = 1'b0;
      for (int i = 0; i < 3; i++) step(1'b0, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      logic [7:0] d;
      void'($urandom(32'd20240611));
      // R10, R7: default reset, fastest rate
      do_reset(1'b0);
      seg_tag = "R7";
      run_bus(400);
      // R4: long frame on the default rate
      do_write(8'h00, 1'b1);
      run_bus(400);
      // R1: each prescaler code with rate select zero
      seg_tag = "R1";
      for (int c = 0; c < 4; c++) begin
         d = 8'(c << 4);
         do_write(d, c[0]);
         run_bus(pre_of(c[1:0]) * 176 + 40);
      end
      // R6: restart in mid count
      seg_tag = "R6";
      do_write(8'h01, 1'b0);
      run_bus(51);
      do_write(8'h12, 1'b0);
      run_bus(60);
      do_write(8'h00, 1'b0);
      run_bus(7);
      do_write(8'h21, 1'b1);
      run_bus(30);
      // R8: boot reset value
      do_reset(1'b1);
      seg_tag = "R8";
      run_bus(3400);
      boot_sel = 1'b0;
      // R2: random register values, with filler in unused bits
      seg_tag = "R2";
      for (int s = 0; s < 6; s++) begin
         d = 8'($urandom);
         d[2] = 1'b0;
         do_write(d, 1'($urandom));
         for (int j = 0; j < ($urandom % 3); j++) step(1'b0, 8'h00);
         run_bus(3000);
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule